// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block picks, out of a parameterised set of interrupt sources, the single pending source that should be presented to a processor. Each source comes with an eligibility bit, an 8-bit priority, and a flag that says whether it has a valid target. An upstream stage works out which sources are eligible. A later stage uses the result to drive the processor's request lines.

A one-cycle start strobe begins a rescan. The block walks the sources one per cycle in ascending ID order. It reads the eligibility mask one 32-bit group at a time. After the walk it spends one more cycle on an optional outside candidate, which has its own ID and priority and competes under the same rule. When that cycle ends, it raises a one-cycle completion strobe and updates the registered result: winning ID, winning priority and a valid flag.

A lower priority number means more urgent. At equal priority the smaller ID wins. The all-ones priority value means "nothing pending".

Top module: `pend_scan_sel`

## Requirements
- R1: Among eligible sources with their target flag set, the one with the numerically smallest priority is reported.
- R2: When several such sources share the smallest priority, the one with the smallest ID is reported. When the outside candidate's priority equals the scan winner's, the smaller of the two IDs is reported.
- R3: If no source qualifies, the published result is `bestValid`=0, `bestPrio`=0xFF and `bestId`=0. A source whose priority is 0xFF is never reported.
- R4: An eligible source whose target flag is clear is left out of the comparison. The block does not clear or change anything for it, so a later scan with the flag set selects it.
- R5: The outside candidate takes part only when `extEn`=1 and `extPrio`≠0xFF. It is compared after the scan, using the rules of R1 and R2.
- R6: The eligibility mask is read in 32-bit groups. A group is loaded when the scan enters it at an index that is a multiple of 32. Sources on either side of a group boundary (IDs 31, 32, 63 with the default size) are selected correctly.
- R7: `done` is a single-cycle pulse. It goes high exactly NUM_IRQ+1 clock cycles after the edge that samples `start`.
- R8: `bestId`, `bestPrio` and `bestValid` change only in the cycle in which `done` is high. Input changes at other times leave them unchanged.
- R9: A `start` during a scan restarts the scan from index 0. No `done` is produced for the abandoned scan.
- R10: `bestValid` is 1 exactly when the published `bestPrio` is not 0xFF. It is registered together with `done`.
- R11: After reset, `done`=0, `bestValid`=0, `bestPrio`=0xFF and `bestId`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins or restarts a scan |
| eligMask | input | NUM_IRQ | Per-source eligibility, bit i for ID i |
| prioFlat | input | NUM_IRQ*PRIO_W | Priority of ID i in bits [i*PRIO_W +: PRIO_W] |
| targetOk | input | NUM_IRQ | Per-source flag: a valid target exists |
| extEn | input | 1 | Enables the outside candidate |
| extId | input | ID_W | ID of the outside candidate |
| extPrio | input | PRIO_W | Priority of the outside candidate |
| done | output | 1 | One-cycle pulse when a new result is published |
| bestValid | output | 1 | Published result is a real interrupt |
| bestId | output | ID_W | Published winning ID (0 if none) |
| bestPrio | output | PRIO_W | Published winning priority (0xFF if none) |

## Verification
The running best register can hold a bad priority or ID. The port only shows this when the pass finishes, in the result published with `done`, NUM_IRQ+1 cycles after start. So the bench compares every published result with a model computed from the inputs.

A fault in the scan counter or state sequence appears as a `done` pulse at the wrong cycle, or a missing one. A group register loaded at the wrong index shows up as wrong winners near the 32-source boundaries. Directed boundary cases and a latency check on every scan expose both within one scan.

// File: rtl/pend_sel_pkg.sv
package pend_sel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EXT  = 2'd2
  } scanState_t;

  typedef struct packed {
    logic clear;    // reset running best, load first group
    logic loadGrp;  // load the next mask group
    logic step;     // evaluate the source at the scan index
    logic publish;  // evaluate outside candidate and register result
  } scanStrobe_t;

endpackage

// File: rtl/pend_sel_ctrl.sv
module pend_sel_ctrl
  import pend_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int GROUP_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int GRP_LSB = $clog2(GROUP_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output scanStrobe_t      strobe,
  output logic [IDX_W-1:0] scanIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IRQ - 1);

  scanState_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else if (start) begin
      state   <= ST_SCAN;
      scanIdx <= '0;
    end else begin
      case (state)
        ST_SCAN: begin
          if (scanIdx == LAST_IDX) state <= ST_EXT;
          else scanIdx <= scanIdx + 1'b1;
        end
        ST_EXT: begin
          state   <= ST_IDLE;
          scanIdx <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic atGroupEnd;
  assign atGroupEnd = (scanIdx[GRP_LSB-1:0] == {GRP_LSB{1'b1}}) && (scanIdx != LAST_IDX);

  always_comb begin
    strobe.clear   = start;
    strobe.step    = (state == ST_SCAN) && !start;
    strobe.loadGrp = start || ((state == ST_SCAN) && !start && atGroupEnd);
    strobe.publish = (state == ST_EXT) && !start;
  end

endmodule

// File: rtl/pend_sel_dp.sv
module pend_sel_dp
  import pend_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W = 8,
  parameter int ID_W = 8,
  parameter int GROUP_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ),
  localparam int GRP_LSB = $clog2(GROUP_W),
  localparam int NUM_GRP = (NUM_IRQ + GROUP_W - 1) / GROUP_W,
  localparam int PAD_W = NUM_GRP * GROUP_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  scanStrobe_t               strobe,
  input  logic [IDX_W-1:0]          scanIdx,
  input  logic [NUM_IRQ-1:0]        eligMask,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [NUM_IRQ-1:0]        targetOk,
  input  logic                      extEn,
  input  logic [ID_W-1:0]           extId,
  input  logic [PRIO_W-1:0]         extPrio,
  output logic                      done,
  output logic                      bestValid,
  output logic [ID_W-1:0]           bestId,
  output logic [PRIO_W-1:0]         bestPrio
);

  localparam logic [PRIO_W-1:0] NONE_PRIO = {PRIO_W{1'b1}};

  logic [PAD_W-1:0]   maskPad;
  logic [GROUP_W-1:0] grpReg;
  logic [IDX_W:0]     grpBase;
  logic [PRIO_W-1:0]  curPrio;
  logic [ID_W-1:0]    curId;

  always_comb begin
    maskPad = '0;
    for (int j = 0; j < NUM_IRQ; j++) maskPad[j] = eligMask[j];
  end

  always_comb begin
    if (strobe.clear) grpBase = '0;
    else grpBase = ((({1'b0, scanIdx}) >> GRP_LSB) + 1'b1) << GRP_LSB;
  end

  // candidate at the scan index
  logic              candHit;
  logic [PRIO_W-1:0] candPrio;
  assign candPrio = prioFlat[scanIdx*PRIO_W +: PRIO_W];
  assign candHit  = grpReg[scanIdx[GRP_LSB-1:0]] && targetOk[scanIdx] && (candPrio < curPrio);

  // outside candidate against the scan winner
  logic              extWins;
  logic [PRIO_W-1:0] finPrio;
  logic [ID_W-1:0]   finId;
  always_comb begin
    extWins = extEn && (extPrio != NONE_PRIO) &&
              ((extPrio < curPrio) || ((extPrio == curPrio) && (extId < curId)));
    finPrio = extWins ? extPrio : curPrio;
    finId   = extWins ? extId : curId;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpReg  <= '0;
      curPrio <= NONE_PRIO;
      curId   <= '0;
    end else begin
      if (strobe.loadGrp) grpReg <= maskPad[grpBase +: GROUP_W];
      if (strobe.clear) begin
        curPrio <= NONE_PRIO;
        curId   <= '0;
      end else if (strobe.step && candHit) begin
        curPrio <= candPrio;
        curId   <= ID_W'(scanIdx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      bestValid <= 1'b0;
      bestId    <= '0;
      bestPrio  <= NONE_PRIO;
    end else begin
      done <= strobe.publish;
      if (strobe.publish) begin
        bestValid <= (finPrio != NONE_PRIO);
        bestId    <= finId;
        bestPrio  <= finPrio;
      end
    end
  end

endmodule

// File: rtl/pend_scan_sel.sv
module pend_scan_sel
  import pend_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W = 8,
  parameter int ID_W = 8,
  parameter int GROUP_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NUM_IRQ-1:0]        eligMask,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [NUM_IRQ-1:0]        targetOk,
  input  logic                      extEn,
  input  logic [ID_W-1:0]           extId,
  input  logic [PRIO_W-1:0]         extPrio,
  output logic                      done,
  output logic                      bestValid,
  output logic [ID_W-1:0]           bestId,
  output logic [PRIO_W-1:0]         bestPrio
);

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] scanIdx;

  pend_sel_ctrl #(.NUM_IRQ(NUM_IRQ), .GROUP_W(GROUP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe), .scanIdx(scanIdx)
  );

  pend_sel_dp #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W), .GROUP_W(GROUP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .eligMask(eligMask), .prioFlat(prioFlat), .targetOk(targetOk),
    .extEn(extEn), .extId(extId), .extPrio(extPrio),
    .done(done), .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio)
  );

endmodule

// File: rtl/pend_sel_chk.sv
module pend_sel_chk #(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W = 8,
  parameter int ID_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              extEn,
  input logic [PRIO_W-1:0] extPrio,
  input logic              done,
  input logic              bestValid,
  input logic [ID_W-1:0]   bestId,
  input logic [PRIO_W-1:0] bestPrio
);

  localparam logic [PRIO_W-1:0] NONE_PRIO = {PRIO_W{1'b1}};

  // cycles since the edge that sampled start
  logic [31:0] sinceStart;
  logic        seenStart;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceStart <= '0;
      seenStart  <= 1'b0;
    end else if (start) begin
      sinceStart <= '0;
      seenStart  <= 1'b1;
    end else if (sinceStart != 32'hFFFF_FFFF) begin
      sinceStart <= sinceStart + 1;
    end
  end

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (seenStart && sinceStart == 32'(NUM_IRQ + 1)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(bestId) && $stable(bestPrio) && $stable(bestValid)));

  p_ext_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(extEn) && ($past(extPrio) != NONE_PRIO)) |-> bestValid);

  p_none_id_r3: assert property (@(posedge clk) disable iff (!rstN)
    !bestValid |-> (bestId == '0));

endmodule

bind pend_scan_sel pend_sel_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .extEn(extEn), .extPrio(extPrio),
  .done(done), .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio)
);

// File: tb/pend_scan_sel_tb.sv
module pend_scan_sel_tb;
  localparam int NUM = 64;
  localparam int PW = 8;
  localparam int IW = 8;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NUM-1:0] elig = '0;
  logic [NUM*PW-1:0] prio = '1;
  logic [NUM-1:0] tgt = '0;
  logic extEn = 1'b0;
  logic [IW-1:0] extId = '0;
  logic [PW-1:0] extPrio = '1;
  logic done, bestValid;
  logic [IW-1:0] bestId;
  logic [PW-1:0] bestPrio;

  int nTests = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pend_scan_sel #(.NUM_IRQ(NUM), .PRIO_W(PW), .ID_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .eligMask(elig), .prioFlat(prio),
    .targetOk(tgt), .extEn(extEn), .extId(extId), .extPrio(extPrio),
    .done(done), .bestValid(bestValid), .bestId(bestId), .bestPrio(bestPrio)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected winner from the requirements
  function automatic void model(output logic v, output logic [IW-1:0] id, output logic [PW-1:0] p);
    p = '1; id = '0;
    for (int i = 0; i < NUM; i++)
      if (elig[i] && tgt[i] && prio[i*PW +: PW] < p) begin
        p = prio[i*PW +: PW]; id = IW'(i);
      end
    if (extEn && extPrio != '1 && (extPrio < p || (extPrio == p && extId < id))) begin
      p = extPrio; id = extId;
    end
    v = (p != '1);
  endfunction

  task automatic setPrio(input int i, input logic [PW-1:0] v);
    prio[i*PW +: PW] = v;
  endtask

  task automatic clearAll();
    elig = '0; tgt = '1; prio = '1; extEn = 1'b0; extId = '0; extPrio = '1;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // start is sampled at the edge right after it is raised; count edges to done
  task automatic runScan(input string tag);
    int cyc;
    logic ev; logic [IW-1:0] eid; logic [PW-1:0] ep;
    model(ev, eid, ep);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(posedge clk); #1; cyc++;
    end
    check({tag, " R7 latency"}, cyc, NUM + 1);
    check({tag, " R1 id"}, bestId, eid);
    check({tag, " R1 prio"}, bestPrio, ep);
    check({tag, " R10 valid"}, bestValid, ev);
    @(posedge clk); #1;
    check({tag, " R7 single pulse"}, done, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nTests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [IW-1:0] hId; logic [PW-1:0] hPrio; logic hV;
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    #1;
    check("R11 done", done, 0);
    check("R11 valid", bestValid, 0);
    check("R11 prio", bestPrio, 8'hFF);
    check("R11 id", bestId, 0);
    @(negedge clk); rstN = 1'b1;

    // R3: nothing eligible
    clearAll(); runScan("R3 empty");
    check("R3 none id", bestId, 0);
    // R3: eligible source with 0xFF priority never wins
    clearAll(); elig[7] = 1; runScan("R3 ff-prio");
    check("R3 ff not valid", bestValid, 0);

    // R1 basic
    clearAll(); elig[10] = 1; setPrio(10, 8'h40); elig[50] = 1; setPrio(50, 8'h20);
    runScan("R1 lower wins"); check("R1 chose 50", bestId, 50);

    // R2 ties
    clearAll(); elig[5] = 1; setPrio(5, 3); elig[40] = 1; setPrio(40, 3);
    runScan("R2 tie"); check("R2 chose 5", bestId, 5);

    // R4 target clear skipped, still selectable later
    clearAll(); elig[2] = 1; setPrio(2, 1); tgt[2] = 0; elig[9] = 1; setPrio(9, 8);
    runScan("R4 skip"); check("R4 chose 9", bestId, 9);
    tgt[2] = 1; runScan("R4 later"); check("R4 chose 2", bestId, 2);

    // R5 outside candidate
    clearAll(); elig[20] = 1; setPrio(20, 8'h10);
    extEn = 1; extId = 8'd100; extPrio = 8'h08; runScan("R5 ext wins");
    check("R5 ext id", bestId, 100);
    extPrio = 8'h10; extId = 8'd3; runScan("R5 ext tie low id");
    check("R2 ext tie", bestId, 3);
    extId = 8'd30; runScan("R5 ext tie high id");
    check("R2 ext loses tie", bestId, 20);
    extEn = 0; extPrio = 8'h01; runScan("R5 ext off");
    check("R5 disabled", bestId, 20);
    clearAll(); extEn = 1; extPrio = 8'hFF; extId = 8'd9; runScan("R5 ext ff");
    check("R5 ff ignored", bestValid, 0);
    extPrio = 8'hFE; runScan("R5 ext alone");
    check("R5 ext alone id", bestId, 9);

    // R6 group boundaries
    clearAll(); elig[31] = 1; setPrio(31, 5); runScan("R6 id31");
    clearAll(); elig[32] = 1; setPrio(32, 5); runScan("R6 id32");
    clearAll(); elig[63] = 1; setPrio(63, 5); elig[0] = 1; setPrio(0, 6); runScan("R6 id63");
    check("R6 chose 63", bestId, 63);

    // R8 outputs hold while inputs change
    hId = bestId; hPrio = bestPrio; hV = bestValid;
    @(negedge clk); elig = '1; prio = '0; extEn = 1; extPrio = 0;
    repeat (5) @(negedge clk);
    check("R8 id hold", bestId, hId);
    check("R8 prio hold", bestPrio, hPrio);
    check("R8 valid hold", bestValid, hV);

    // R9 restart mid-scan
    clearAll(); elig[12] = 1; setPrio(12, 9);
    pulseStart();
    repeat (20) @(negedge clk);
    check("R9 no early done", done, 0);
    elig[44] = 1; setPrio(44, 2);
    begin
      int cyc; bit sawDone;
      sawDone = 0;
      @(negedge clk); start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
      cyc = 0;
      while (!done && cyc < 1000) begin @(posedge clk); #1; cyc++; end
      check("R9 restart latency", cyc, NUM + 1);
      check("R9 restart id", bestId, 44);
    end

    // random
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < NUM; i++) begin
        elig[i] = ($urandom % 3) != 0;
        tgt[i] = ($urandom % 5) != 0;
        prio[i*PW +: PW] = PW'($urandom % 24) + 8'hE8 * PW'($urandom % 2 == 0);
      end
      extEn = $urandom % 2;
      extId = IW'($urandom % 128);
      extPrio = PW'($urandom);
      runScan("R1 random");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule